// File: doc/BRIEF.md
# Store Queue with Age-Ordered Load Forwarding

This block keeps every store of an out-of-order core in a 32-entry ring, in program order, from the moment the store is dispatched until it is written to the data cache. Each store receives an age tag when it is allocated at the tail. Its address and its data arrive later, on two independent write ports that name the entry by that tag. A commit pulse marks the oldest not-yet-committed store as completed. A store whose address and data are both present and which has been committed is offered to the data cache from the head, one store at a time and never out of order.

Loads query the queue with their address and an age tag. The age tag is the store-queue tail value captured when the load was dispatched. The block searches every live store that is older than the load and has a known address. If there are matching stores, it takes the youngest of them. If that store's data is present, the data is forwarded. If its data is not yet present, the load is told to stall. If no older store matches, the load is told to read the cache instead. A flush discards every uncommitted store at once, while committed stores keep draining.

Top module: `sq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, the queue is empty: `full` is 0, `wr_valid` is 0 and `alloc_tag` is 0.
- R2: In a cycle with `alloc_valid` high, `full` low and `flush` low, the store at the tail is given the tag shown on `alloc_tag`, and `alloc_tag` then advances by one, modulo 64. Bits [4:0] of the tag are the entry index and bit 5 is the wrap bit. `full` is 1 exactly when 32 stores are live. While `full` is 1, an allocation request is ignored and `alloc_tag` does not move.
- R3: `wr_valid` is high only when the head store has its address, has its data and has been committed. `wr_addr` and `wr_data` are that store's address and data. These outputs stay unchanged until `wr_ready` is seen, and each handshake retires exactly one store, in allocation order.
- R4: A `commit` pulse marks the oldest uncommitted live store as completed. It is ignored when no uncommitted store exists.
- R5: A load with tag L compares its address against every live store whose tag lies in [head, L) and whose address is known. When several of these match, `ld_hit` is 1 and `ld_data` carries the data of the youngest matching store.
- R6: When the youngest older matching store has no data yet, `ld_stall` is 1 and `ld_hit` is 0.
- R7: When no older store with a known address matches, `ld_miss` is 1. Stores whose address is unknown, and stores that are not older than the load, never affect the result.
- R8: `flush` moves the tail back to the commit pointer, after applying a commit made in the same cycle, so that the next `alloc_tag` equals that pointer. An allocation in the flush cycle is ignored. Discarded stores are never forwarded or written, and committed stores keep draining.
- R9: With `ld_valid` low, `ld_hit`, `ld_stall` and `ld_miss` are all 0. With `ld_valid` high, exactly one of them is 1.
- R10: A load whose tag lies outside [head, tail] sees no older store and gets `ld_miss`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate one store at the tail |
| alloc_tag | output | 6 | Tag the next allocated store receives |
| full | output | 1 | All 32 entries live |
| addr_valid | input | 1 | Address write for a live store |
| addr_tag | input | 6 | Tag of the store receiving the address |
| addr_value | input | 32 | Store address |
| data_valid | input | 1 | Data write for a live store |
| data_tag | input | 6 | Tag of the store receiving the data |
| data_value | input | 32 | Store data |
| commit | input | 1 | Mark the oldest uncommitted store completed |
| flush | input | 1 | Discard all uncommitted stores |
| ld_valid | input | 1 | Load lookup request |
| ld_tag | input | 6 | Store-queue tail captured at load dispatch |
| ld_addr | input | 32 | Load address |
| ld_hit | output | 1 | Data forwarded on ld_data |
| ld_stall | output | 1 | Youngest older match has no data yet |
| ld_miss | output | 1 | No older store matches; read the cache |
| ld_data | output | 32 | Forwarded data, zero unless ld_hit |
| wr_valid | output | 1 | Cache write offered |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | 32 | Cache write address |
| wr_data | output | 32 | Cache write data |

## Verification
The properties assume that address and data writes name only stores that are currently live. They also assume that a load tag is a tail value captured earlier, so that it lies in the live range or has already fallen behind the head. The bench respects both assumptions. It picks write targets only among live stores that still lack the field being written. It forms load tags either inside [head, tail] or a few steps behind the head, which is the R10 case. Apart from that, commit, flush, allocation and cache readiness are driven freely, including commits with nothing left to commit and allocation requests while the queue is full.

// File: rtl/sq_pkg.sv
package sq_pkg;
    parameter int SQ_DEPTH = 32;
    parameter int SQ_AW    = 32;
    parameter int SQ_DW    = 32;
    localparam int IDXW    = $clog2(SQ_DEPTH);
    localparam int TAGW    = IDXW + 1;

    typedef logic [TAGW-1:0]  sq_tag_t;
    typedef logic [IDXW-1:0]  sq_idx_t;
    typedef logic [SQ_AW-1:0] sq_addr_t;
    typedef logic [SQ_DW-1:0] sq_data_t;

    typedef enum logic [1:0] {LD_NONE, LD_HIT, LD_STALL, LD_MISS} ld_res_e;

    typedef struct packed {
        logic     aok;
        logic     dok;
        sq_addr_t addr;
        sq_data_t data;
    } sq_entry_t;

    // distance from the head, modulo twice the depth
    function automatic sq_tag_t age_of(sq_tag_t t, sq_tag_t head);
        return t - head;
    endfunction

    function automatic sq_idx_t idx_of(sq_tag_t t);
        return t[IDXW-1:0];
    endfunction
endpackage

// File: rtl/sq_ptrs.sv
module sq_ptrs
    import sq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    alloc_req,
    input  logic    commit_req,
    input  logic    flush,
    input  logic    drain_fire,
    output sq_tag_t head,
    output sq_tag_t cmt,
    output sq_tag_t tail,
    output logic    full,
    output logic    alloc_go
);
    logic cmt_go;
    sq_tag_t cmt_n;

    assign full     = (tail - head) == sq_tag_t'(SQ_DEPTH);
    assign cmt_go   = commit_req && (cmt != tail);
    assign alloc_go = alloc_req && !full && !flush;
    assign cmt_n    = cmt + sq_tag_t'(cmt_go);

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            cmt  <= '0;
            tail <= '0;
        end else begin
            head <= head + sq_tag_t'(drain_fire);
            cmt  <= cmt_n;
            if (flush)
                tail <= cmt_n;
            else
                tail <= tail + sq_tag_t'(alloc_go);
        end
    end
endmodule

// File: rtl/sq_store.sv
module sq_store
    import sq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      alloc_go,
    input  sq_idx_t   alloc_idx,
    input  logic      awr_v,
    input  sq_idx_t   awr_idx,
    input  sq_addr_t  awr_addr,
    input  logic      dwr_v,
    input  sq_idx_t   dwr_idx,
    input  sq_data_t  dwr_data,
    output sq_entry_t ent [SQ_DEPTH]
);
    for (genvar e = 0; e < SQ_DEPTH; e++) begin : g_ent
        sq_entry_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                if (alloc_go && alloc_idx == sq_idx_t'(e)) begin
                    q.aok <= 1'b0;
                    q.dok <= 1'b0;
                end
                if (awr_v && awr_idx == sq_idx_t'(e)) begin
                    q.aok  <= 1'b1;
                    q.addr <= awr_addr;
                end
                if (dwr_v && dwr_idx == sq_idx_t'(e)) begin
                    q.dok  <= 1'b1;
                    q.data <= dwr_data;
                end
            end
        end
        assign ent[e] = q;
    end
endmodule

// File: rtl/sq_fwd.sv
module sq_fwd
    import sq_pkg::*;
(
    input  sq_entry_t ent [SQ_DEPTH],
    input  sq_tag_t   head,
    input  sq_tag_t   tail,
    input  logic      ld_valid,
    input  sq_tag_t   ld_tag,
    input  sq_addr_t  ld_addr,
    output ld_res_e   res,
    output sq_data_t  fdata
);
    always_comb begin
        sq_tag_t live;
        sq_tag_t span;
        sq_idx_t di;
        sq_idx_t best_i;
        sq_idx_t best_d;
        logic    found;

        live   = tail - head;
        span   = age_of(ld_tag, head);
        if (span > live)
            span = '0;
        found  = 1'b0;
        best_i = '0;
        best_d = '0;
        for (int i = 0; i < SQ_DEPTH; i++) begin
            di = sq_idx_t'(i) - head[IDXW-1:0];
            if ({1'b0, di} < span && ent[i].aok && ent[i].addr == ld_addr) begin
                if (!found || di > best_d) begin
                    found  = 1'b1;
                    best_d = di;
                    best_i = sq_idx_t'(i);
                end
            end
        end

        fdata = '0;
        if (!ld_valid)
            res = LD_NONE;
        else if (!found)
            res = LD_MISS;
        else if (ent[best_i].dok) begin
            res   = LD_HIT;
            fdata = ent[best_i].data;
        end else
            res = LD_STALL;
    end
endmodule

// File: rtl/sq_top.sv
module sq_top
    import sq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_valid,
    output logic [TAGW-1:0]  alloc_tag,
    output logic             full,
    input  logic             addr_valid,
    input  logic [TAGW-1:0]  addr_tag,
    input  logic [SQ_AW-1:0] addr_value,
    input  logic             data_valid,
    input  logic [TAGW-1:0]  data_tag,
    input  logic [SQ_DW-1:0] data_value,
    input  logic             commit,
    input  logic             flush,
    input  logic             ld_valid,
    input  logic [TAGW-1:0]  ld_tag,
    input  logic [SQ_AW-1:0] ld_addr,
    output logic             ld_hit,
    output logic             ld_stall,
    output logic             ld_miss,
    output logic [SQ_DW-1:0] ld_data,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [SQ_AW-1:0] wr_addr,
    output logic [SQ_DW-1:0] wr_data
);
    sq_tag_t   head_q, cmt_q, tail_q;
    logic      alloc_go, drain_fire;
    logic      awr_live, dwr_live;
    sq_entry_t ent [SQ_DEPTH];
    sq_entry_t hd;
    ld_res_e   res;

    sq_ptrs u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .alloc_req  (alloc_valid),
        .commit_req (commit),
        .flush      (flush),
        .drain_fire (drain_fire),
        .head       (head_q),
        .cmt        (cmt_q),
        .tail       (tail_q),
        .full       (full),
        .alloc_go   (alloc_go)
    );

    // writes reach only stores inside the live window
    assign awr_live = addr_valid && (age_of(addr_tag, head_q) < age_of(tail_q, head_q));
    assign dwr_live = data_valid && (age_of(data_tag, head_q) < age_of(tail_q, head_q));

    sq_store u_store (
        .clk       (clk),
        .rst       (rst),
        .alloc_go  (alloc_go),
        .alloc_idx (idx_of(tail_q)),
        .awr_v     (awr_live),
        .awr_idx   (idx_of(addr_tag)),
        .awr_addr  (addr_value),
        .dwr_v     (dwr_live),
        .dwr_idx   (idx_of(data_tag)),
        .dwr_data  (data_value),
        .ent       (ent)
    );

    sq_fwd u_fwd (
        .ent      (ent),
        .head     (head_q),
        .tail     (tail_q),
        .ld_valid (ld_valid),
        .ld_tag   (ld_tag),
        .ld_addr  (ld_addr),
        .res      (res),
        .fdata    (ld_data)
    );

    assign hd         = ent[idx_of(head_q)];
    assign wr_valid   = (head_q != cmt_q) && hd.aok && hd.dok;
    assign wr_addr    = hd.addr;
    assign wr_data    = hd.data;
    assign drain_fire = wr_valid && wr_ready;

    assign alloc_tag = tail_q;
    assign ld_hit    = (res == LD_HIT);
    assign ld_stall  = (res == LD_STALL);
    assign ld_miss   = (res == LD_MISS);
endmodule

// File: rtl/sq_chk.sv
module sq_chk
    import sq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             full,
    input logic             flush,
    input logic             commit,
    input logic [TAGW-1:0]  alloc_tag,
    input logic [TAGW-1:0]  head_q,
    input logic [TAGW-1:0]  cmt_q,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [SQ_AW-1:0] wr_addr,
    input logic [SQ_DW-1:0] wr_data,
    input logic             ld_valid,
    input logic             ld_hit,
    input logic             ld_stall,
    input logic             ld_miss
);
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        (alloc_tag - head_q) <= sq_tag_t'(SQ_DEPTH));

    assert_full_holds_tail_R2: assert property (@(posedge clk) disable iff (rst)
        full && !flush |=> $stable(alloc_tag));

    assert_write_held_R3: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    assert_flush_to_commit_R8: assert property (@(posedge clk) disable iff (rst)
        flush && !commit |=> alloc_tag == $past(cmt_q));

    assert_one_result_R9: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> $countones({ld_hit, ld_stall, ld_miss}) == 1);

    assert_idle_result_R9: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |-> !(ld_hit || ld_stall || ld_miss));
endmodule

bind sq_top sq_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .full      (full),
    .flush     (flush),
    .commit    (commit),
    .alloc_tag (alloc_tag),
    .head_q    (head_q),
    .cmt_q     (cmt_q),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ld_valid  (ld_valid),
    .ld_hit    (ld_hit),
    .ld_stall  (ld_stall),
    .ld_miss   (ld_miss)
);

// File: tb/test_sq_top.sv
`timescale 1ns/1ps
module test_sq_top;
    import sq_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, alloc_valid, full, addr_valid, data_valid, commit, flush;
    logic ld_valid, ld_hit, ld_stall, ld_miss, wr_valid, wr_ready;
    logic [5:0]  alloc_tag, addr_tag, data_tag, ld_tag;
    logic [31:0] addr_value, data_value, ld_addr, ld_data, wr_addr, wr_data;

    sq_top i_sq_top (
        .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .full(full),
        .addr_valid(addr_valid), .addr_tag(addr_tag), .addr_value(addr_value),
        .data_valid(data_valid), .data_tag(data_tag), .data_value(data_value),
        .commit(commit), .flush(flush), .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
        .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_miss(ld_miss), .ld_data(ld_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    bit last_flush = 0;

    // reference model: plain counters that never wrap
    int          m_head, m_cmt, m_tail;
    logic [31:0] m_addr [32];
    logic [31:0] m_data [32];
    bit          m_aok  [32];
    bit          m_dok  [32];

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic bit m_wr_valid();
        int h = m_head % 32;
        return (m_head < m_cmt) && m_aok[h] && m_dok[h];
    endfunction

    // kind: 0 miss, 1 hit, 2 stall; outside: tag not in [head, tail]
    task automatic m_lookup(input logic [5:0] lt, input logic [31:0] la,
                            output int kind, output logic [31:0] d, output bit outside);
        int cnt = m_tail - m_head;
        int dl  = (int'(lt) - (m_head % 64) + 64) % 64;
        outside = dl > cnt;
        if (outside) dl = 0;
        kind = 0;
        d    = '0;
        for (int k = 0; k < dl; k++) begin
            int idx = (m_head + k) % 32;
            if (m_aok[idx] && m_addr[idx] == la) begin
                kind = m_dok[idx] ? 1 : 2;
                d    = m_data[idx];
            end
        end
    endtask

    task automatic compare();
        int kind;
        logic [31:0] d;
        bit outside;
        string rq;
        check("R2", "full", {31'b0, full}, {31'b0, (m_tail - m_head) == 32});
        check(last_flush ? "R8" : "R2", "alloc_tag", {26'b0, alloc_tag}, m_tail % 64);
        check("R3 R4", "wr_valid", {31'b0, wr_valid}, {31'b0, m_wr_valid()});
        if (m_wr_valid()) begin
            check("R3", "wr_addr", wr_addr, m_addr[m_head % 32]);
            check("R3", "wr_data", wr_data, m_data[m_head % 32]);
        end
        if (!ld_valid) begin
            check("R9", "idle result", {29'b0, ld_hit, ld_stall, ld_miss}, 32'd0);
        end else begin
            m_lookup(ld_tag, ld_addr, kind, d, outside);
            rq = outside ? "R10" : (kind == 1 ? "R5" : (kind == 2 ? "R6" : "R7"));
            check(rq, "hit/stall/miss", {29'b0, ld_hit, ld_stall, ld_miss},
                  {29'b0, kind == 1, kind == 2, kind == 0});
            if (kind == 1) check(rq, "ld_data", ld_data, d);
        end
    endtask

    task automatic model_edge();
        bit fire = m_wr_valid() && wr_ready;
        bit mfull = (m_tail - m_head) == 32;
        int cn = m_cmt + ((commit && m_cmt < m_tail) ? 1 : 0);
        if (addr_valid) begin m_aok[addr_tag % 32] = 1; m_addr[addr_tag % 32] = addr_value; end
        if (data_valid) begin m_dok[data_tag % 32] = 1; m_data[data_tag % 32] = data_value; end
        if (flush) m_tail = cn;
        else if (alloc_valid && !mfull) begin
            m_aok[m_tail % 32] = 0;
            m_dok[m_tail % 32] = 0;
            m_tail++;
        end
        if (fire) m_head++;
        m_cmt = cn;
        last_flush = flush;
    endtask

    // one clock: inputs already set at the falling edge
    task automatic step();
        #1 compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        alloc_valid = 0; addr_valid = 0; data_valid = 0; commit = 0; flush = 0;
        ld_valid = 0; wr_ready = 0; addr_tag = 0; data_tag = 0; ld_tag = 0;
        addr_value = 0; data_value = 0; ld_addr = 0;
    endtask

    // live store lacking a field; field 0 address, 1 data
    function automatic int pick_missing(int field);
        int cnt = m_tail - m_head;
        int off;
        if (cnt == 0) return -1;
        off = $urandom % cnt;
        for (int k = 0; k < cnt; k++) begin
            int t = m_head + (off + k) % cnt;
            if (field == 0 ? !m_aok[t % 32] : !m_dok[t % 32]) return t;
        end
        return -1;
    endfunction

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        m_head = 0; m_cmt = 0; m_tail = 0;
        for (int i = 0; i < 32; i++) begin m_aok[i] = 0; m_dok[i] = 0; m_addr[i] = 0; m_data[i] = 0; end
        repeat (3) @(negedge clk);
        #1;
        check("R1", "full in reset", {31'b0, full}, 32'd0);
        check("R1", "wr_valid in reset", {31'b0, wr_valid}, 32'd0);
        check("R1", "alloc_tag in reset", {26'b0, alloc_tag}, 32'd0);
        rst = 0;
        @(negedge clk);
        #1 check("R1", "wr_valid after reset", {31'b0, wr_valid}, 32'd0);

        // directed forwarding: tags 0..3; addr 0x10 on 0,1,3; data on 0 and 3
        for (int i = 0; i < 4; i++) begin alloc_valid = 1; step(); end
        alloc_valid = 0;
        for (int i = 0; i < 4; i++) begin
            if (i != 2) begin addr_valid = 1; addr_tag = 6'(i); addr_value = 32'h10; end
            if (i == 0 || i == 3) begin data_valid = 1; data_tag = 6'(i); data_value = 32'hA0 + i; end
            step();
            addr_valid = 0; data_valid = 0;
        end
        ld_valid = 1; ld_addr = 32'h10;
        ld_tag = 4; step();
        #1 check("R5", "youngest of several matches", ld_data, 32'hA3);
        ld_tag = 3; step();
        ld_tag = 2; step();
        ld_tag = 1; step();
        ld_tag = 0; step();
        ld_addr = 32'h20; ld_tag = 4; step();
        ld_valid = 0;

        // fill to full; extra requests ignored
        alloc_valid = 1;
        repeat (30) step();
        #1 check("R2", "full after 32 allocations", {31'b0, full}, 32'd1);
        step();

        // flush with nothing committed; then commit two, flush again
        alloc_valid = 0; flush = 1; step(); flush = 0;
        #1 check("R8", "tail back to commit pointer", {26'b0, alloc_tag}, 32'd0);
        alloc_valid = 1; repeat (3) step(); alloc_valid = 0;
        commit = 1; step(); step(); commit = 0;
        flush = 1; alloc_valid = 1; step(); flush = 0; alloc_valid = 0;
        wr_ready = 1; repeat (3) step(); wr_ready = 0;

        // mixed traffic
        for (int c = 0; c < 4000; c++) begin
            int t;
            int lo;
            idle_inputs();
            alloc_valid = ($urandom % 3) != 0;
            commit      = ($urandom % 3) == 0;
            wr_ready    = ($urandom % 2) == 0;
            flush       = ($urandom % 80) == 0;
            t = pick_missing(0);
            if (t >= 0 && ($urandom % 2) == 0) begin
                addr_valid = 1; addr_tag = 6'(t % 64); addr_value = 32'($urandom % 6);
            end
            t = pick_missing(1);
            if (t >= 0 && ($urandom % 2) == 0) begin
                data_valid = 1; data_tag = 6'(t % 64); data_value = $urandom;
            end
            ld_valid = ($urandom % 4) != 0;
            ld_addr  = 32'($urandom % 6);
            if (($urandom % 8) == 0) lo = m_head - 1 - int'($urandom % 8);
            else lo = m_head + int'($urandom % (m_tail - m_head + 1));
            ld_tag = 6'((lo + 64) % 64);
            step();
        end

        // drain everything
        idle_inputs();
        for (int c = 0; c < 200 && m_head != m_tail; c++) begin
            int t;
            idle_inputs();
            commit = 1; wr_ready = 1;
            t = pick_missing(0);
            if (t >= 0) begin addr_valid = 1; addr_tag = 6'(t % 64); addr_value = 32'h55; end
            t = pick_missing(1);
            if (t >= 0) begin data_valid = 1; data_tag = 6'(t % 64); data_value = 32'h66; end
            step();
        end
        idle_inputs();
        step();
        #1 check("R3", "empty after drain", {31'b0, wr_valid}, 32'd0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule